// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block manages the privilege side of trap handling in a core with four privilege levels, numbered 0 (least privileged) to 3 (most privileged). When the core raises an exception, the block picks the handler address from the vector table of the target level. It copies the interrupted PC and status word into that level's private link and saved-status registers, and it moves the core to the target level. When the core asks to return, the block reads back the link and saved-status registers of the current level. It hands them back to the core and lowers the level to the one recorded in the restored status word.

Level 0 never takes an exception, so only levels 1 to 3 own a vector base, a link register and a saved-status register. Each vector table has sixteen 128-byte slots. Two things pick the slot: the kind of exception, and where it came from. The source can be the same level running on the level-0 stack, the same level running on its own stack, a lower level in 64-bit state, or a lower level in 32-bit state. A small write port loads the vector bases. Fetching from the handler address, decoding and forming syndrome values are left to the surrounding core.

Top module: `exc_entry_ret`

## Requirements
- R1: After reset the level is 3, `redirect` and `fault` are 0, and all vector bases, link registers and saved-status registers are zero.
- R2: The cycle after an accepted exception, `redirect_pc` equals the vector base of the target level plus group×0x200 plus kind×0x80. The kind codes are synchronous=0, IRQ=1, FIQ=2, system error=3.
- R3: The group is 0 when the target equals the current level and `sp_own_in`=0. It is 1 when the target equals the current level and `sp_own_in`=1. It is 2 when the target is above the current level and `low32_in`=0, and 3 when the target is above the current level and `low32_in`=1.
- R4: An accepted exception raises `redirect` for one cycle and sets the level to `tgt_lvl`. It sets `status_out` to `status_in` with bits [1:0] replaced by the target level.
- R5: An accepted exception stores `pc_in` and `status_in` into the target level's link and saved-status registers. A return at level L drives those registers of L onto `redirect_pc` and `status_out`, raises `redirect`, and sets the level to bits [1:0] of the restored status. Registers of other levels keep their values.
- R6: If several exception requests arrive in one cycle, synchronous wins. Among the asynchronous ones, system error beats FIQ, and FIQ beats IRQ.
- R7: An exception whose target is 0 or below the current level is ignored. `fault` pulses for one cycle, and level, `redirect` and all banked registers are unchanged.
- R8: A return requested at level 0 is ignored and pulses `fault`. The level stays 0.
- R9: A vector-base write with `vb_sel`=1..3 stores `vb_wdata` with its low 11 bits cleared, and a write with `vb_sel`=0 changes nothing. The new base is used from the next cycle. An exception in the same cycle as the write uses the old base.
- R10: An exception request and a return request in the same cycle: the exception is handled and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | ADDR_W | PC of the interrupted code |
| status_in | input | STAT_W | Status word of the interrupted code; bits [1:0] are the level field |
| sp_own_in | input | 1 | Current level runs on its own stack (1) or on the level-0 stack (0) |
| low32_in | input | 1 | Interrupted code runs in 32-bit state |
| sync_req | input | 1 | Synchronous exception request |
| irq_req | input | 1 | IRQ request |
| fiq_req | input | 1 | FIQ request |
| serr_req | input | 1 | System-error request |
| tgt_lvl | input | LVL_W | Target level of the requested exception |
| eret_req | input | 1 | Exception-return request |
| vb_we | input | 1 | Vector-base write enable |
| vb_sel | input | LVL_W | Level whose vector base is written |
| vb_wdata | input | ADDR_W | Vector-base write data |
| lvl_out | output | LVL_W | Current privilege level |
| redirect | output | 1 | One-cycle pulse: jump to `redirect_pc` |
| redirect_pc | output | ADDR_W | Handler address or restored PC |
| status_out | output | STAT_W | New status word to install |
| fault | output | 1 | One-cycle pulse: request ignored as illegal |

## Verification
Several things can land on the same clock edge. Two are checked on purpose here. First, a vector-base write can coincide with an exception entry to that same level. The bench drives both in one cycle and expects the old base in `redirect_pc`, then the new base on the following entry. Second, an exception request can coincide with a return request, and separately several exception kinds can be raised together. These cases are judged by the slot offset and by whether the banked registers behave as if only the exception happened. A sweep over every current level, target level, kind, stack choice and state flag compares each handler address and each round-trip return against arithmetic in the bench.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      KIND_SYNC = 2'd0,
      KIND_IRQ  = 2'd1,
      KIND_FIQ  = 2'd2,
      KIND_SERR = 2'd3
   } exc_kind_e;

   typedef enum logic [1:0] {
      GRP_SAME_SP0 = 2'd0,
      GRP_SAME_SPX = 2'd1,
      GRP_LOW_64   = 2'd2,
      GRP_LOW_32   = 2'd3
   } vec_grp_e;

   // group chosen from source context
   function automatic vec_grp_e pick_group(input logic same_lvl,
                                           input logic sp_own,
                                           input logic low32);
      if (same_lvl) return sp_own ? GRP_SAME_SPX : GRP_SAME_SP0;
      return low32 ? GRP_LOW_32 : GRP_LOW_64;
   endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic      sync_req,
   input  logic      irq_req,
   input  logic      fiq_req,
   input  logic      serr_req,
   input  logic      eret_req,
   output logic      take_exc,
   output exc_kind_e kind,
   output logic      take_ret
);
   always_comb begin
      take_exc = sync_req | irq_req | fiq_req | serr_req;
      if (sync_req)      kind = KIND_SYNC;
      else if (serr_req) kind = KIND_SERR;
      else if (fiq_req)  kind = KIND_FIQ;
      else               kind = KIND_IRQ;
      // an exception pre-empts a return in the same cycle
      take_ret = eret_req & ~take_exc;
   end
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
   import exc_pkg::*;
#(
   parameter int NUM_LVL = 4,
   parameter int ADDR_W  = 32,
   parameter int LVL_W   = 2,
   parameter int SLOT_LG = 7
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [LVL_W-1:0]  cur_lvl,
   input  logic [LVL_W-1:0]  tgt_lvl,
   input  logic              sp_own,
   input  logic              low32,
   input  exc_kind_e         kind,
   output logic [ADDR_W-1:0] handler,
   output logic              legal
);
   vec_grp_e   grp;
   logic [3:0] slot;

   always_comb begin
      grp     = pick_group(tgt_lvl == cur_lvl, sp_own, low32);
      slot    = {grp, kind};
      handler = base + (ADDR_W'(slot) << SLOT_LG);
      legal   = (tgt_lvl != '0) && (tgt_lvl >= cur_lvl)
                && (int'(tgt_lvl) < NUM_LVL);
   end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
   parameter int NUM_LVL  = 4,
   parameter int ADDR_W   = 32,
   parameter int STAT_W   = 8,
   parameter int LVL_W    = 2,
   parameter int ALIGN_LG = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vb_we,
   input  logic [LVL_W-1:0]  vb_sel,
   input  logic [ADDR_W-1:0] vb_wdata,
   input  logic              sv_en,
   input  logic [LVL_W-1:0]  sv_lvl,
   input  logic [ADDR_W-1:0] sv_pc,
   input  logic [STAT_W-1:0] sv_st,
   input  logic [LVL_W-1:0]  vec_lvl,
   output logic [ADDR_W-1:0] vec_base,
   input  logic [LVL_W-1:0]  ret_lvl,
   output logic [ADDR_W-1:0] ret_pc,
   output logic [STAT_W-1:0] ret_st
);
   logic [NUM_LVL-1:0][ADDR_W-1:0] base_v;
   logic [NUM_LVL-1:0][ADDR_W-1:0] link_v;
   logic [NUM_LVL-1:0][STAT_W-1:0] stat_v;

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      if (g == 0) begin : g_none
         // level 0 never takes exceptions: no storage
         assign base_v[g] = '0;
         assign link_v[g] = '0;
         assign stat_v[g] = '0;
      end else begin : g_reg
         logic [ADDR_W-1:0] base_q;
         logic [ADDR_W-1:0] link_q;
         logic [STAT_W-1:0] stat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q <= '0;
               link_q <= '0;
               stat_q <= '0;
            end else begin
               if (vb_we && vb_sel == LVL_W'(g))
                  base_q <= {vb_wdata[ADDR_W-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
               if (sv_en && sv_lvl == LVL_W'(g)) begin
                  link_q <= sv_pc;
                  stat_q <= sv_st;
               end
            end
         end
         assign base_v[g] = base_q;
         assign link_v[g] = link_q;
         assign stat_v[g] = stat_q;
      end
   end

   assign vec_base = base_v[vec_lvl];
   assign ret_pc   = link_v[ret_lvl];
   assign ret_st   = stat_v[ret_lvl];
endmodule

// File: rtl/exc_entry_ret.sv
module exc_entry_ret
   import exc_pkg::*;
#(
   parameter int NUM_LVL    = 4,
   parameter int ADDR_W     = 32,
   parameter int STAT_W     = 8,
   parameter int SLOT_BYTES = 128,
   localparam int LVL_W     = $clog2(NUM_LVL),
   localparam int SLOT_LG   = $clog2(SLOT_BYTES),
   localparam int ALIGN_LG  = SLOT_LG + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [STAT_W-1:0] status_in,
   input  logic              sp_own_in,
   input  logic              low32_in,
   input  logic              sync_req,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic              serr_req,
   input  logic [LVL_W-1:0]  tgt_lvl,
   input  logic              eret_req,
   input  logic              vb_we,
   input  logic [LVL_W-1:0]  vb_sel,
   input  logic [ADDR_W-1:0] vb_wdata,
   output logic [LVL_W-1:0]  lvl_out,
   output logic              redirect,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic [STAT_W-1:0] status_out,
   output logic              fault
);
   // elaboration-time parameter checks
   if (NUM_LVL < 2 || NUM_LVL > 4) begin : g_bad_lvl
      $error("NUM_LVL must be 2..4");
   end
   if ((1 << SLOT_LG) != SLOT_BYTES) begin : g_bad_slot
      $error("SLOT_BYTES must be a power of two");
   end
   if (ALIGN_LG >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for one vector table");
   end
   if (STAT_W <= LVL_W) begin : g_bad_stat
      $error("STAT_W must exceed the level field");
   end

   logic              take_exc, take_ret, legal;
   exc_kind_e         kind;
   logic [ADDR_W-1:0] vec_base, handler, ret_pc;
   logic [STAT_W-1:0] ret_st;
   logic [LVL_W-1:0]  lvl_q;
   logic              redirect_q, fault_q;
   logic [ADDR_W-1:0] pc_q;
   logic [STAT_W-1:0] st_q;

   exc_arbiter u_arb (
      .sync_req (sync_req),
      .irq_req  (irq_req),
      .fiq_req  (fiq_req),
      .serr_req (serr_req),
      .eret_req (eret_req),
      .take_exc (take_exc),
      .kind     (kind),
      .take_ret (take_ret)
   );

   exc_vec_calc #(
      .NUM_LVL (NUM_LVL),
      .ADDR_W  (ADDR_W),
      .LVL_W   (LVL_W),
      .SLOT_LG (SLOT_LG)
   ) u_vec (
      .base    (vec_base),
      .cur_lvl (lvl_q),
      .tgt_lvl (tgt_lvl),
      .sp_own  (sp_own_in),
      .low32   (low32_in),
      .kind    (kind),
      .handler (handler),
      .legal   (legal)
   );

   exc_bank #(
      .NUM_LVL  (NUM_LVL),
      .ADDR_W   (ADDR_W),
      .STAT_W   (STAT_W),
      .LVL_W    (LVL_W),
      .ALIGN_LG (ALIGN_LG)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .vb_we    (vb_we),
      .vb_sel   (vb_sel),
      .vb_wdata (vb_wdata),
      .sv_en    (take_exc & legal),
      .sv_lvl   (tgt_lvl),
      .sv_pc    (pc_in),
      .sv_st    (status_in),
      .vec_lvl  (tgt_lvl),
      .vec_base (vec_base),
      .ret_lvl  (lvl_q),
      .ret_pc   (ret_pc),
      .ret_st   (ret_st)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q      <= LVL_W'(NUM_LVL - 1);
         redirect_q <= 1'b0;
         fault_q    <= 1'b0;
         pc_q       <= '0;
         st_q       <= '0;
      end else begin
         redirect_q <= 1'b0;
         fault_q    <= 1'b0;
         if (take_exc) begin
            if (legal) begin
               lvl_q      <= tgt_lvl;
               redirect_q <= 1'b1;
               pc_q       <= handler;
               st_q       <= {status_in[STAT_W-1:LVL_W], tgt_lvl};
            end else begin
               fault_q <= 1'b1;
            end
         end else if (take_ret) begin
            if (lvl_q == '0) begin
               fault_q <= 1'b1;
            end else begin
               lvl_q      <= ret_st[LVL_W-1:0];
               redirect_q <= 1'b1;
               pc_q       <= ret_pc;
               st_q       <= ret_st;
            end
         end
      end
   end

   assign lvl_out     = lvl_q;
   assign redirect    = redirect_q;
   assign redirect_pc = pc_q;
   assign status_out  = st_q;
   assign fault       = fault_q;
endmodule

// File: rtl/exc_entry_ret_chk.sv
module exc_entry_ret_chk #(
   parameter int NUM_LVL = 4,
   parameter int ADDR_W  = 32,
   parameter int STAT_W  = 8,
   parameter int LVL_W   = 2,
   parameter int SLOT_LG = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_req,
   input logic              irq_req,
   input logic              fiq_req,
   input logic              serr_req,
   input logic              eret_req,
   input logic [LVL_W-1:0]  tgt_lvl,
   input logic [LVL_W-1:0]  lvl_out,
   input logic              redirect,
   input logic [ADDR_W-1:0] redirect_pc,
   input logic [STAT_W-1:0] status_out,
   input logic              fault
);
   logic any_exc, ok_exc;
   assign any_exc = sync_req | irq_req | fiq_req | serr_req;
   assign ok_exc  = any_exc && tgt_lvl != '0 && tgt_lvl >= lvl_out;

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (lvl_out == LVL_W'(NUM_LVL - 1)) && !redirect && !fault);

   p_slot_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ok_exc |=> redirect_pc[SLOT_LG-1:0] == '0);

   p_enter_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ok_exc |=> redirect && lvl_out == $past(tgt_lvl)
                 && status_out[LVL_W-1:0] == $past(tgt_lvl));

   p_sync_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_exc && sync_req) |=> redirect_pc[SLOT_LG+1:SLOT_LG] == 2'd0);

   p_bad_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_exc && !ok_exc) |=> fault && !redirect && $stable(lvl_out));

   p_ret_l0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !any_exc && lvl_out == '0) |=> fault && !redirect && lvl_out == '0);

   p_ret_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !any_exc && lvl_out != '0) |=> redirect
                 && lvl_out == status_out[LVL_W-1:0]);

   p_exc_over_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && ok_exc) |=> lvl_out == $past(tgt_lvl));
endmodule

bind exc_entry_ret exc_entry_ret_chk #(
   .NUM_LVL (NUM_LVL),
   .ADDR_W  (ADDR_W),
   .STAT_W  (STAT_W),
   .LVL_W   (LVL_W),
   .SLOT_LG (SLOT_LG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_req    (sync_req),
   .irq_req     (irq_req),
   .fiq_req     (fiq_req),
   .serr_req    (serr_req),
   .eret_req    (eret_req),
   .tgt_lvl     (tgt_lvl),
   .lvl_out     (lvl_out),
   .redirect    (redirect),
   .redirect_pc (redirect_pc),
   .status_out  (status_out),
   .fault       (fault)
);

// File: tb/exc_entry_ret_tb.sv
module exc_entry_ret_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_in = '0;
   logic [7:0]  status_in = '0;
   logic        sp_own_in = 1'b0, low32_in = 1'b0;
   logic        sync_req = 1'b0, irq_req = 1'b0, fiq_req = 1'b0, serr_req = 1'b0;
   logic [1:0]  tgt_lvl = '0;
   logic        eret_req = 1'b0;
   logic        vb_we = 1'b0;
   logic [1:0]  vb_sel = '0;
   logic [31:0] vb_wdata = '0;
   logic [1:0]  lvl_out;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic [7:0]  status_out;
   logic        fault;

   int errors = 0;
   int checks = 0;
   int n = 0;
   logic [31:0] vb [4];

   always #10 clk = ~clk;

   exc_entry_ret u_dut (
      .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .status_in(status_in),
      .sp_own_in(sp_own_in), .low32_in(low32_in), .sync_req(sync_req),
      .irq_req(irq_req), .fiq_req(fiq_req), .serr_req(serr_req),
      .tgt_lvl(tgt_lvl), .eret_req(eret_req), .vb_we(vb_we), .vb_sel(vb_sel),
      .vb_wdata(vb_wdata), .lvl_out(lvl_out), .redirect(redirect),
      .redirect_pc(redirect_pc), .status_out(status_out), .fault(fault)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear;
      sync_req = 0; irq_req = 0; fiq_req = 0; serr_req = 0;
      eret_req = 0; vb_we = 0;
   endtask

   task automatic set_kind(input int k);
      sync_req = (k == 0); irq_req = (k == 1);
      fiq_req  = (k == 2); serr_req = (k == 3);
   endtask

   task automatic enter(input int t, input int k, input logic s, input logic a,
                        input logic [31:0] pc, input logic [7:0] st);
      tgt_lvl = 2'(t); set_kind(k); sp_own_in = s; low32_in = a;
      pc_in = pc; status_in = st;
      step; clear;
   endtask

   task automatic do_ret;
      eret_req = 1; step; clear;
   endtask

   task automatic wr_vb(input int sel, input logic [31:0] d);
      vb_we = 1; vb_sel = 2'(sel); vb_wdata = d; step; clear;
   endtask

   task automatic go_level(input int l);
      enter(3, 0, 1'b0, 1'b0, 32'hDEAD_0000, {6'h2A, 2'(l)});
      do_ret;
   endtask

   function automatic logic [31:0] exp_pc(input int c, input int t, input int k,
                                          input logic s, input logic a);
      int grp;
      if (c == t) grp = s ? 1 : 0;
      else        grp = a ? 3 : 2;
      return vb[t] + 32'(grp * 512) + 32'(k * 128);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      report;
   end

   initial begin
      vb[0] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 level", 32'(lvl_out), 32'd3);
      chk("R1 redirect", 32'(redirect), 32'd0);
      chk("R1 fault", 32'(fault), 32'd0);
      enter(3, 0, 1'b1, 1'b0, 32'h0, 8'h03);
      chk("R1 base zero", redirect_pc, 32'h0000_0280 - 32'h80);

      // R9 base writes, low bits cleared, sel 0 ignored
      wr_vb(1, 32'h0000_1000);        vb[1] = 32'h0000_1000;
      wr_vb(2, 32'h0002_0BFF);        vb[2] = 32'h0002_0800;
      wr_vb(3, 32'h4000_07FF);        vb[3] = 32'h4000_0000;
      wr_vb(0, 32'hFFFF_F800);
      enter(3, 0, 1'b0, 1'b0, 32'h0, 8'h03);
      chk("R9 base3 low bits cleared", redirect_pc, vb[3]);
      go_level(1);
      enter(2, 0, 1'b0, 1'b0, 32'h0, 8'h01);
      chk("R9 base2 after sel0 write", redirect_pc, vb[2] + 32'h400);

      // full sweep: R2 R3 R4 R5 R7
      for (int c = 0; c < 4; c++)
         for (int t = 0; t < 4; t++)
            for (int k = 0; k < 4; k++)
               for (int s = 0; s < 2; s++)
                  for (int a = 0; a < 2; a++) begin
                     logic [31:0] pcv;
                     logic [7:0]  stv;
                     n++;
                     pcv = 32'h1000_0000 + 32'(n * 4);
                     stv = {6'(c * 5 + t + k + s), 2'(c)};
                     go_level(c);
                     chk("R5 level reached", 32'(lvl_out), 32'(c));
                     enter(t, k, 1'(s), 1'(a), pcv, stv);
                     if (t != 0 && t >= c) begin
                        chk("R2 R3 handler", redirect_pc, exp_pc(c, t, k, 1'(s), 1'(a)));
                        chk("R4 redirect", 32'(redirect), 32'd1);
                        chk("R4 level", 32'(lvl_out), 32'(t));
                        chk("R4 status", 32'(status_out), 32'({stv[7:2], 2'(t)}));
                        do_ret;
                        chk("R5 ret pc", redirect_pc, pcv);
                        chk("R5 ret status", 32'(status_out), 32'(stv));
                        chk("R5 ret level", 32'(lvl_out), 32'(c));
                     end else begin
                        chk("R7 fault", 32'(fault), 32'd1);
                        chk("R7 no redirect", 32'(redirect), 32'd0);
                        chk("R7 level kept", 32'(lvl_out), 32'(c));
                     end
                  end

      // R7 ignored exception leaves bank intact
      go_level(3);
      enter(3, 0, 1'b0, 1'b0, 32'hAAAA_0000, 8'h0E);  // bank3 -> level 2 on ret
      do_ret;
      enter(2, 0, 1'b0, 1'b0, 32'hBBBB_0000, 8'h11);  // bank2 -> level 1
      enter(1, 0, 1'b0, 1'b0, 32'hCCCC_0000, 8'h22);  // below level 2: ignored
      chk("R7 fault on low target", 32'(fault), 32'd1);
      // R5 banking: entering level 3 leaves level 2 copy intact
      enter(3, 1, 1'b0, 1'b0, 32'hDDDD_0000, 8'h36);
      do_ret;
      chk("R5 ret from 3", redirect_pc, 32'hDDDD_0000);
      chk("R5 ret level 2", 32'(lvl_out), 32'd2);
      do_ret;
      chk("R5 bank2 kept", redirect_pc, 32'hBBBB_0000);
      chk("R5 bank2 status", 32'(status_out), 32'h11);
      chk("R5 level 1", 32'(lvl_out), 32'd1);

      // R8 return at level 0
      go_level(0);
      do_ret;
      chk("R8 fault", 32'(fault), 32'd1);
      chk("R8 no redirect", 32'(redirect), 32'd0);
      chk("R8 level stays 0", 32'(lvl_out), 32'd0);

      // R6 priority
      go_level(3);
      tgt_lvl = 3; sp_own_in = 1; sync_req = 1; irq_req = 1; fiq_req = 1; serr_req = 1;
      step; clear;
      chk("R6 sync wins", redirect_pc, vb[3] + 32'h200);
      tgt_lvl = 3; irq_req = 1; fiq_req = 1; serr_req = 1;
      step; clear;
      chk("R6 serr over fiq irq", redirect_pc, vb[3] + 32'h380);
      tgt_lvl = 3; irq_req = 1; fiq_req = 1;
      step; clear;
      chk("R6 fiq over irq", redirect_pc, vb[3] + 32'h300);

      // R9 write in same cycle as entry uses old base
      tgt_lvl = 3; sp_own_in = 0; sync_req = 1;
      vb_we = 1; vb_sel = 3; vb_wdata = 32'h7000_0000;
      step; clear;
      chk("R9 same-cycle old base", redirect_pc, vb[3]);
      vb[3] = 32'h7000_0000;
      enter(3, 0, 1'b0, 1'b0, 32'h0, 8'h03);
      chk("R9 new base next", redirect_pc, vb[3]);

      // R10 exception and return together
      go_level(1);
      tgt_lvl = 2; irq_req = 1; eret_req = 1; pc_in = 32'h5555_0000;
      status_in = 8'h41; sp_own_in = 0; low32_in = 1;
      step; clear;
      chk("R10 exception taken", redirect_pc, vb[2] + 32'h680);
      chk("R10 level", 32'(lvl_out), 32'd2);
      do_ret;
      chk("R10 bank saved", redirect_pc, 32'h5555_0000);
      chk("R10 back to 1", 32'(lvl_out), 32'd1);

      report;
   end
endmodule